// File: doc/BRIEF.md
# Keyboard Scan Debounce and Key FIFO

This block sits behind a keyboard scan counter. For every scanned row it receives the row number and the eight latched return lines. It turns those inputs into stored bytes in one 8-entry by 8-bit memory, and a mode input selects how that memory is used.

In scanned-keyboard mode, a closure is debounced over repeated visits to its row. An accepted key is queued once as a code that packs the modifier inputs with its row and column. In strobed mode, the return lines are queued on every rising edge of a strobe input. In both of these modes the memory is a first-in first-out queue, and the block reports fill count, full, empty, a sticky overrun flag and an interrupt line. In sensor-matrix mode the memory is instead a live image of the sensor array: each scanned row overwrites its own entry, and the host reads any entry by address.

The host reads the queue head combinationally and removes it with a one-cycle read pulse. Changing the mode empties the queue and restarts debouncing.

Top module: `kbd_scan_fifo`

## Requirements
- R1: After reset, count_o is 0, empty_o is 1, and full_o, irq_o and overrun_o are 0.
- R2: In scan mode (mode_i = 0), a return bit at 1 means closed. On a row pulse with any bit closed while the debouncer is idle, the row and the lowest closed column become a candidate. The key is queued on the DEB_SCANS-th later pulse of that row on which the same column is still closed, and count_o rises on the next cycle. The code is bit 7 = ctrl_i, bit 6 = shift_i, bits 5:3 = row, bits 2:0 = column.
- R3: In scan mode, if the candidate column reads open on a visit before acceptance, nothing is queued and the debouncer returns to idle.
- R4: A key held after acceptance queues no further entries until its row is scanned with it open. A new press after that is queued again.
- R5: In strobed mode (mode_i = 2 or 3), each 0-to-1 transition of strobe_i queues ret_i once, however long strobe_i stays high. Row pulses are ignored in strobed mode, and strobe_i is ignored in scan mode.
- R6: rd_data_o shows the oldest queued entry. A rd_en_i pulse removes it, so entries leave in arrival order. rd_en_i on an empty queue has no effect.
- R7: count_o gives the number of queued entries. full_o is 1 at 8 entries and empty_o is 1 at 0 entries. irq_o is 1 exactly when the mode is not sensor mode and the queue is not empty.
- R8: A write into a full queue is dropped, leaves the contents and count unchanged, and sets overrun_o. overrun_o stays set until the mode changes.
- R9: In sensor mode (mode_i = 1), a row pulse writes ret_i into entry row_idx_i, and rd_data_o shows entry rd_addr_i. In this mode count_o stays 0, irq_o stays 0, and rd_en_i and strobe_i have no effect.
- R10: A change of mode_i empties the queue and clears overrun_o one cycle later, and the debouncer restarts from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | 0 scan, 1 sensor, 2 or 3 strobed |
| row_valid_i | input | 1 | One-cycle pulse: a scanned row's return lines are valid |
| row_idx_i | input | 3 | Row being scanned |
| ret_i | input | 8 | Latched return lines, 1 = closed |
| shift_i | input | 1 | Shift modifier level |
| ctrl_i | input | 1 | Control modifier level |
| strobe_i | input | 1 | Strobed-mode write strobe |
| rd_en_i | input | 1 | Remove queue head |
| rd_addr_i | input | 3 | Sensor image entry to read |
| rd_data_o | output | 8 | Queue head or addressed sensor entry |
| count_o | output | 4 | Entries queued |
| full_o | output | 1 | Queue full |
| empty_o | output | 1 | Queue empty |
| irq_o | output | 1 | Data available |
| overrun_o | output | 1 | Sticky dropped-write flag |

## Verification
Every stored result (count, flags, queue head, sensor entry) appears one cycle after the clock edge that sampled the stimulus. rd_data_o follows the stored state with no extra delay. The bench changes inputs on falling edges and samples one falling edge later, so each check lands in the first cycle where the new value is due. Debounce acceptance falls on the DEB_SCANS-th revisit of the candidate row. The bench therefore checks the count after the full scan pass just before that revisit and again after the pass that contains it.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;

    typedef enum logic [1:0] {
        KM_SCAN       = 2'd0,
        KM_SENSOR     = 2'd1,
        KM_STROBE     = 2'd2,
        KM_STROBE_ALT = 2'd3
    } kmode_e;

    typedef enum logic [1:0] {
        DB_IDLE = 2'd0,
        DB_WAIT = 2'd1,
        DB_HELD = 2'd2
    } db_state_e;

endpackage

// File: rtl/kbd_debounce.sv
module kbd_debounce
    import kbd_scan_pkg::*;
#(
    parameter int ROWS      = 8,
    parameter int COLS      = 8,
    parameter int DEB_SCANS = 4,
    localparam int RW       = $clog2(ROWS),
    localparam int CW       = $clog2(COLS),
    localparam int CODEW    = 2 + RW + CW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             row_valid_i,
    input  logic [RW-1:0]    row_idx_i,
    input  logic [COLS-1:0]  ret_i,
    input  logic             shift_i,
    input  logic             ctrl_i,
    output logic             push_o,
    output logic [CODEW-1:0] code_o
);

    localparam int CNTW = $clog2(DEB_SCANS + 1);

    typedef struct packed {
        db_state_e       st;
        logic [RW-1:0]   row;
        logic [CW-1:0]   col;
        logic [CNTW-1:0] cnt;
    } db_t;

    db_t q, d;
    logic [CW-1:0] low_col;
    logic          any_closed;

    always_comb begin
        any_closed = |ret_i;
        low_col    = '0;
        for (int i = COLS - 1; i >= 0; i--) begin
            if (ret_i[i]) low_col = CW'(i);
        end

        d      = q;
        push_o = 1'b0;
        code_o = {ctrl_i, shift_i, q.row, q.col};

        if (!enable_i) begin
            d.st  = DB_IDLE;
            d.cnt = '0;
        end else if (row_valid_i) begin
            unique case (q.st)
                DB_IDLE: begin
                    if (any_closed) begin
                        d.st  = DB_WAIT;
                        d.row = row_idx_i;
                        d.col = low_col;
                        d.cnt = '0;
                    end
                end
                DB_WAIT: begin
                    if (row_idx_i == q.row) begin
                        if (ret_i[q.col]) begin
                            if (q.cnt == CNTW'(DEB_SCANS - 1)) begin
                                push_o = 1'b1;
                                d.st   = DB_HELD;
                            end else begin
                                d.cnt = q.cnt + 1'b1;
                            end
                        end else begin
                            d.st = DB_IDLE;
                        end
                    end
                end
                DB_HELD: begin
                    if (row_idx_i == q.row && !ret_i[q.col]) d.st = DB_IDLE;
                end
                default: d.st = DB_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= DB_IDLE;
            q.row <= '0;
            q.col <= '0;
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/kbd_store.sv
module kbd_store #(
    parameter int DEPTH  = 8,
    parameter int WIDTH  = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNTW  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             sensor_i,
    input  logic             push_i,
    input  logic [WIDTH-1:0] push_data_i,
    input  logic             row_wr_i,
    input  logic [AW-1:0]    row_addr_i,
    input  logic [WIDTH-1:0] row_data_i,
    input  logic             pop_i,
    input  logic [AW-1:0]    rd_addr_i,
    output logic [WIDTH-1:0] rd_data_o,
    output logic [CNTW-1:0]  count_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             overrun_o
);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [AW-1:0]               wr;
        logic [AW-1:0]               rd;
        logic [CNTW-1:0]             count;
        logic                        ovr;
    } st_t;

    st_t q, d;
    logic inc, dec;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d   = q;
        inc = 1'b0;
        dec = 1'b0;
        if (flush_i) begin
            d.wr    = '0;
            d.rd    = '0;
            d.count = '0;
            d.ovr   = 1'b0;
        end else if (sensor_i) begin
            if (row_wr_i) d.mem[row_addr_i] = row_data_i;
        end else begin
            if (push_i) begin
                if (q.count == CNTW'(DEPTH)) begin
                    d.ovr = 1'b1;
                end else begin
                    d.mem[q.wr] = push_data_i;
                    d.wr        = step(q.wr);
                    inc         = 1'b1;
                end
            end
            if (pop_i && q.count != '0) begin
                d.rd = step(q.rd);
                dec  = 1'b1;
            end
            d.count = q.count + CNTW'(inc) - CNTW'(dec);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.mem   <= '0;
            q.wr    <= '0;
            q.rd    <= '0;
            q.count <= '0;
            q.ovr   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign rd_data_o = sensor_i ? q.mem[rd_addr_i] : q.mem[q.rd];
    assign count_o   = q.count;
    assign full_o    = (q.count == CNTW'(DEPTH));
    assign empty_o   = (q.count == '0);
    assign overrun_o = q.ovr;

endmodule

// File: rtl/kbd_scan_fifo.sv
module kbd_scan_fifo
    import kbd_scan_pkg::*;
#(
    parameter int ROWS      = 8,
    parameter int COLS      = 8,
    parameter int DEB_SCANS = 4,
    localparam int RW       = $clog2(ROWS),
    localparam int CW       = $clog2(COLS),
    localparam int CNTW     = $clog2(ROWS + 1),
    localparam int CODEW    = 2 + RW + CW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode_i,
    input  logic            row_valid_i,
    input  logic [RW-1:0]   row_idx_i,
    input  logic [COLS-1:0] ret_i,
    input  logic            shift_i,
    input  logic            ctrl_i,
    input  logic            strobe_i,
    input  logic            rd_en_i,
    input  logic [RW-1:0]   rd_addr_i,
    output logic [COLS-1:0] rd_data_o,
    output logic [CNTW-1:0] count_o,
    output logic            full_o,
    output logic            empty_o,
    output logic            irq_o,
    output logic            overrun_o
);

    typedef struct packed {
        logic [1:0] mode;
        logic       strobe;
    } top_t;

    top_t q, d;

    logic             flush, is_scan, is_sensor, is_strobe;
    logic             db_push, strobe_rise, push;
    logic [CODEW-1:0] db_code;
    logic [COLS-1:0]  push_data;

    always_comb begin
        d.mode      = mode_i;
        d.strobe    = strobe_i;
        flush       = (mode_i != q.mode);
        is_scan     = (mode_i == KM_SCAN);
        is_sensor   = (mode_i == KM_SENSOR);
        is_strobe   = mode_i[1];
        strobe_rise = strobe_i && !q.strobe;
        push        = !flush && ((is_scan && db_push) || (is_strobe && strobe_rise));
        push_data   = is_strobe ? ret_i : COLS'(db_code);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.mode   <= KM_SCAN;
            q.strobe <= 1'b0;
        end else begin
            q <= d;
        end
    end

    kbd_debounce #(
        .ROWS      (ROWS),
        .COLS      (COLS),
        .DEB_SCANS (DEB_SCANS)
    ) u_deb (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (is_scan && !flush),
        .row_valid_i (row_valid_i),
        .row_idx_i   (row_idx_i),
        .ret_i       (ret_i),
        .shift_i     (shift_i),
        .ctrl_i      (ctrl_i),
        .push_o      (db_push),
        .code_o      (db_code)
    );

    kbd_store #(
        .DEPTH (ROWS),
        .WIDTH (COLS)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush),
        .sensor_i    (is_sensor),
        .push_i      (push),
        .push_data_i (push_data),
        .row_wr_i    (is_sensor && row_valid_i),
        .row_addr_i  (row_idx_i),
        .row_data_i  (ret_i),
        .pop_i       (rd_en_i),
        .rd_addr_i   (rd_addr_i),
        .rd_data_o   (rd_data_o),
        .count_o     (count_o),
        .full_o      (full_o),
        .empty_o     (empty_o),
        .overrun_o   (overrun_o)
    );

    assign irq_o = !is_sensor && !empty_o;

endmodule

// File: rtl/kbd_scan_fifo_chk.sv
module kbd_scan_fifo_chk #(
    parameter int DEPTH = 8,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      mode_i,
    input logic            row_valid_i,
    input logic            rd_en_i,
    input logic [CNTW-1:0] count_o,
    input logic            full_o,
    input logic            empty_o,
    input logic            irq_o,
    input logic            overrun_o
);

    logic [1:0] mode_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_seen <= 2'd0;
        else        mode_seen <= mode_i;
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CNTW'(DEPTH)); // R7

    AST_IRQ_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !empty_o); // R7

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_o && mode_i == mode_seen) |=> overrun_o); // R8

    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !rd_en_i && mode_i == mode_seen) |=> full_o); // R8

    AST_SENSOR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && mode_i == 2'd1 && mode_seen == 2'd1) |=> (empty_o && !irq_o)); // R9

    AST_SCAN_NEEDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd0 && mode_seen == 2'd0 && !row_valid_i) |=> count_o <= $past(count_o)); // R2

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != mode_seen) |=> (count_o == '0 && !overrun_o)); // R10

endmodule

bind kbd_scan_fifo kbd_scan_fifo_chk #(.DEPTH(ROWS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .row_valid_i (row_valid_i),
    .rd_en_i     (rd_en_i),
    .count_o     (count_o),
    .full_o      (full_o),
    .empty_o     (empty_o),
    .irq_o       (irq_o),
    .overrun_o   (overrun_o)
);

// File: tb/kbd_scan_fifo_test.sv
module kbd_scan_fifo_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEB        = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic       row_valid_i = 1'b0;
    logic [2:0] row_idx_i = '0;
    logic [7:0] ret_i = '0;
    logic       shift_i = 1'b0, ctrl_i = 1'b0, strobe_i = 1'b0, rd_en_i = 1'b0;
    logic [2:0] rd_addr_i = '0;
    logic [7:0] rd_data_o;
    logic [3:0] count_o;
    logic       full_o, empty_o, irq_o, overrun_o;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    kbd_scan_fifo #(.ROWS(8), .COLS(8), .DEB_SCANS(DEB)) uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .row_valid_i(row_valid_i),
        .row_idx_i(row_idx_i), .ret_i(ret_i), .shift_i(shift_i), .ctrl_i(ctrl_i),
        .strobe_i(strobe_i), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
        .rd_data_o(rd_data_o), .count_o(count_o), .full_o(full_o),
        .empty_o(empty_o), .irq_o(irq_o), .overrun_o(overrun_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic scan_row(input int r, input logic [7:0] v);
        @(negedge clk);
        row_valid_i = 1'b1;
        row_idx_i   = 3'(r);
        ret_i       = v;
        @(negedge clk);
        row_valid_i = 1'b0;
        ret_i       = '0;
    endtask

    task automatic scan_pass(input int target, input logic [7:0] v);
        for (int r = 0; r < 8; r++) scan_row(r, (r == target) ? v : 8'h00);
    endtask

    task automatic pulse_strobe(input logic [7:0] v);
        @(negedge clk);
        ret_i    = v;
        strobe_i = 1'b1;
        @(negedge clk);
        strobe_i = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk);
        rd_en_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        mode_i = m;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 count", count_o, 0);
        chk("R1 empty", empty_o, 1);
        chk("R1 full", full_o, 0);
        chk("R1 irq", irq_o, 0);
        chk("R1 overrun", overrun_o, 0);
    endtask

    task automatic t_scan_accept();
        shift_i = 1'b1; ctrl_i = 1'b0;
        for (int p = 0; p < DEB; p++) scan_pass(2, 8'h28);
        chk("R2 not yet accepted", count_o, 0);
        scan_pass(2, 8'h28);
        chk("R2 accepted count", count_o, 1);
        chk("R2 code lowest column", rd_data_o, 8'h53);
        chk("R7 irq set", irq_o, 1);
        for (int p = 0; p < 3; p++) scan_pass(2, 8'h28);
        chk("R4 held key single entry", count_o, 1);
        scan_pass(2, 8'h00);
        shift_i = 1'b0; ctrl_i = 1'b1;
        for (int p = 0; p < DEB + 1; p++) scan_pass(2, 8'h28);
        chk("R4 new press after release", count_o, 2);
        chk("R6 head oldest", rd_data_o, 8'h53);
        pop();
        chk("R6 second entry", rd_data_o, 8'h93);
        pop();
        chk("R6 drained", count_o, 0);
        chk("R7 irq clear", irq_o, 0);
        pop();
        chk("R6 pop empty ignored", count_o, 0);
        ctrl_i = 1'b0;
    endtask

    task automatic t_bounce();
        scan_pass(5, 8'h01);
        scan_pass(5, 8'h01);
        scan_pass(5, 8'h00);
        chk("R3 bounce dropped", count_o, 0);
        for (int p = 0; p < DEB; p++) scan_pass(5, 8'h01);
        chk("R3 restart from detect", count_o, 0);
        scan_pass(5, 8'h01);
        chk("R3 accepted after restart", count_o, 1);
        chk("R3 code", rd_data_o, 8'h28);
        pulse_strobe(8'h77);
        chk("R5 strobe ignored in scan", count_o, 1);
    endtask

    task automatic t_strobe();
        set_mode(2'd2);
        chk("R10 flush on mode change", count_o, 0);
        @(negedge clk);
        ret_i = 8'h10; strobe_i = 1'b1;
        repeat (3) @(negedge clk);
        strobe_i = 1'b0;
        chk("R5 one entry per edge", count_o, 1);
        scan_row(1, 8'hFF);
        chk("R5 row pulse ignored", count_o, 1);
        for (int i = 1; i < 8; i++) pulse_strobe(8'(8'h10 + i));
        chk("R7 count full", count_o, 8);
        chk("R7 full flag", full_o, 1);
        chk("R8 no overrun yet", overrun_o, 0);
        pulse_strobe(8'hEE);
        chk("R8 overrun set", overrun_o, 1);
        chk("R8 count unchanged", count_o, 8);
        chk("R8 head unchanged", rd_data_o, 8'h10);
        for (int i = 0; i < 8; i++) begin
            chk("R6 order", rd_data_o, 8'h10 + i);
            pop();
        end
        chk("R7 empty after drain", empty_o, 1);
        chk("R8 overrun sticky", overrun_o, 1);
        set_mode(2'd3);
        chk("R10 overrun cleared", overrun_o, 0);
        pulse_strobe(8'hA5);
        chk("R5 alt strobe code", count_o, 1);
        chk("R5 alt strobe data", rd_data_o, 8'hA5);
    endtask

    task automatic t_sensor();
        set_mode(2'd1);
        chk("R10 flush to sensor", count_o, 0);
        for (int r = 0; r < 8; r++) scan_row(r, 8'(r * 37 + 5));
        for (int r = 0; r < 8; r++) begin
            @(negedge clk);
            rd_addr_i = 3'(r);
            #1;
            chk("R9 sensor row image", rd_data_o, (r * 37 + 5) & 8'hFF);
        end
        rd_addr_i = 3'd4;
        pop();
        pulse_strobe(8'h99);
        chk("R9 count stays zero", count_o, 0);
        chk("R9 irq low", irq_o, 0);
        chk("R9 entry untouched", rd_data_o, (4 * 37 + 5) & 8'hFF);
        scan_row(4, 8'h3C);
        chk("R9 row overwritten", rd_data_o, 8'h3C);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_scan_accept();
        t_bounce();
        t_strobe();
        t_sensor();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule